// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps calendar time as a bank of eight byte-wide registers, all held as packed BCD: a control byte, seconds, minutes, hours, a weekday byte that also carries a century flag, day of month, month and a two-digit year. A one-cycle pulse on the tick input advances the time by one second. Each second can carry into the minute, the hour, the day, the month and the year. The day of month wraps according to the length of the current month, and February has 29 days in leap years.

Software reaches the bank through a synchronous write port and a combinational read port, both addressed by a 3-bit register offset. Before a time field is written, its value is masked to the field's width and checked against the field's legal range. A write that fails the check is dropped, so the stored time is always legal BCD. Bit 7 of the seconds byte is an oscillator-halt flag that freezes the time. The control byte has fixed bits that are forced on every write. A parameter sets the base year that the two-digit year counts from, and the leap-year test uses that base year.

Top module: `tod_regbank`

## Requirements
- R1: After reset, the registers read as follows: control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday byte 0x01, date 0x01, month 0x01, year 0x00. The register offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year.
- R2: A tick steps the seconds up in BCD. Seconds 0x59 wrap to 0x00 and add one minute. Minutes 0x59 wrap to 0x00 and add one hour. Hours 0x23 wrap to 0x00 and add one day.
- R3: When a day is added and the date is already the last day of the month, the date becomes 0x01 and the month advances; otherwise the date steps up by one. Months 4, 6, 9 and 11 have 30 days and February has 28 days, or 29 when (year + BASE_YEAR) is divisible by 4; every other month has 31. The weekday (bits 2:0 of offset 4) steps up on every added day, and after 7 it goes to 1.
- R4: When month 0x12 advances, it wraps to 0x01 and adds one year. Year 0x99 wraps to 0x00.
- R5: Bit 7 of the seconds register is a halt flag. While it is 1, ticks change nothing. Once it is 0, counting continues from the held time. Every write to offset 1 loads the halt flag from bit 7 of the write data, whether or not the seconds value is accepted. A read of offset 1 returns the halt flag in bit 7 and the BCD seconds in bits 6:0.
- R6: A write to seconds or minutes takes bits 6:0 as BCD. The write is stored only when both digits are legal and the value is 0x00 to 0x59; otherwise the register keeps its value.
- R7: A write to hours takes bits 5:0 as BCD and is stored only for 0x00 to 0x23; otherwise it is ignored.
- R8: A write to the date takes bits 5:0 and is stored only for 0x01 to 0x31, so zero is ignored. A write to the month takes bits 4:0 and is stored only for 0x01 to 0x12.
- R9: A write to the year uses the full byte and is stored only when both nibbles are 0 to 9.
- R10: A write to control stores (data & 0x5F) | 0x90. Bits 7 and 4 therefore always read 1 and bit 5 always reads 0.
- R11: A write to offset 4 keeps bit 6 as the century flag and bits 2:0 as the weekday, and drops all other bits. A read of offset 4 returns the century flag in bit 6 and the weekday in bits 2:0, with the other bits 0.
- R12: When an accepted write and a tick arrive in the same cycle, the written field takes the written value and every other field advances as the tick requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse: advance time by one second |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |

## Verification
The properties assume that a tick is a single-cycle pulse on a clock edge and that writes and ticks are synchronous to clk. The check that a rejected hours write leaves the register unchanged applies only in cycles without a tick, because a tick may legally move the hour. The bench drives every input from its own tasks at the falling edge and holds at most one write and one tick per cycle. Random data covers legal and illegal codes alike. Directed cases set up the month-end, leap-year, year-wrap and halt conditions.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int NUM_REGS = 8;
    localparam int OFF_W    = $clog2(NUM_REGS);

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL = 3'd0,
        OFF_SEC  = 3'd1,
        OFF_MIN  = 3'd2,
        OFF_HOUR = 3'd3,
        OFF_WDAY = 3'd4,
        OFF_DATE = 3'd5,
        OFF_MON  = 3'd6,
        OFF_YEAR = 3'd7
    } tod_off_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       halt;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } tod_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_legal(input logic [7:0] v);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
    endfunction

endpackage

// File: rtl/tod_wr_check.sv
module tod_wr_check
    import tod_pkg::*;
(
    input  tod_off_e   off_i,
    input  logic [7:0] data_i,
    output logic       ok_o,
    output logic [7:0] field_o
);
    always_comb begin
        ok_o    = 1'b1;
        field_o = data_i;
        unique case (off_i)
            OFF_CTRL: field_o = (data_i & 8'h5F) | 8'h90;
            OFF_SEC, OFF_MIN: begin
                field_o = {1'b0, data_i[6:0]};
                ok_o    = bcd_legal(field_o) && (field_o <= 8'h59);
            end
            OFF_HOUR: begin
                field_o = {2'b00, data_i[5:0]};
                ok_o    = bcd_legal(field_o) && (field_o <= 8'h23);
            end
            OFF_DATE: begin
                field_o = {2'b00, data_i[5:0]};
                ok_o    = bcd_legal(field_o) && (field_o != 8'h00) && (field_o <= 8'h31);
            end
            OFF_MON: begin
                field_o = {3'b000, data_i[4:0]};
                ok_o    = bcd_legal(field_o) && (field_o != 8'h00) && (field_o <= 8'h12);
            end
            OFF_YEAR: ok_o = bcd_legal(data_i);
            default:  field_o = data_i;
        endcase
    end
endmodule

// File: rtl/tod_month_len.sv
module tod_month_len #(
    parameter int BASE_YEAR = 1900
) (
    input  logic [4:0] mon_i,
    input  logic [7:0] year_i,
    output logic [5:0] last_o
);
    logic [7:0]  ybin;
    logic [15:0] full;
    logic        leap;

    always_comb begin
        ybin = ({4'b0000, year_i[7:4]} * 8'd10) + {4'b0000, year_i[3:0]};
        full = 16'(BASE_YEAR) + {8'b0, ybin};
        leap = (full[1:0] == 2'b00);
        unique case (mon_i)
            5'h02:                      last_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            default:                    last_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/tod_regbank.sv
module tod_regbank
    import tod_pkg::*;
#(
    parameter int BASE_YEAR = 1900
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       we_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);
    tod_state_t s_d, s_q;
    tod_off_e   off;
    logic       wr_ok;
    logic [7:0] wr_field;
    logic [5:0] last_date;
    logic       run;

    assign off = tod_off_e'(addr_i);

    tod_wr_check u_chk (
        .off_i   (off),
        .data_i  (wdata_i),
        .ok_o    (wr_ok),
        .field_o (wr_field)
    );

    tod_month_len #(.BASE_YEAR(BASE_YEAR)) u_len (
        .mon_i  (s_q.mon),
        .year_i (s_q.year),
        .last_o (last_date)
    );

    assign run = tick_i && !s_q.halt;

    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.sec = 7'(bcd_inc({1'b0, s_q.sec}));
            if (s_q.sec == 7'h59) begin
                s_d.sec = 7'h00;
                s_d.min = 7'(bcd_inc({1'b0, s_q.min}));
                if (s_q.min == 7'h59) begin
                    s_d.min  = 7'h00;
                    s_d.hour = 6'(bcd_inc({2'b00, s_q.hour}));
                    if (s_q.hour == 6'h23) begin
                        s_d.hour = 6'h00;
                        s_d.wday = (s_q.wday == 3'd7) ? 3'd1 : s_q.wday + 3'd1;
                        s_d.date = 6'(bcd_inc({2'b00, s_q.date}));
                        if (s_q.date >= last_date) begin
                            s_d.date = 6'h01;
                            s_d.mon  = 5'(bcd_inc({3'b000, s_q.mon}));
                            if (s_q.mon == 5'h12) begin
                                s_d.mon  = 5'h01;
                                s_d.year = (s_q.year == 8'h99) ? 8'h00 : bcd_inc(s_q.year);
                            end
                        end
                    end
                end
            end
        end
        if (we_i) begin
            unique case (off)
                OFF_CTRL: s_d.ctrl = wr_field;
                OFF_SEC: begin
                    s_d.halt = wdata_i[7];
                    if (wr_ok) s_d.sec = wr_field[6:0];
                end
                OFF_MIN:  if (wr_ok) s_d.min  = wr_field[6:0];
                OFF_HOUR: if (wr_ok) s_d.hour = wr_field[5:0];
                OFF_WDAY: begin
                    s_d.cent = wdata_i[6];
                    s_d.wday = wdata_i[2:0];
                end
                OFF_DATE: if (wr_ok) s_d.date = wr_field[5:0];
                OFF_MON:  if (wr_ok) s_d.mon  = wr_field[4:0];
                OFF_YEAR: if (wr_ok) s_d.year = wr_field;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ctrl: 8'h90, halt: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
                     cent: 1'b0, wday: 3'd1, date: 6'h01, mon: 5'h01, year: 8'h00};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (off)
            OFF_CTRL: rdata_o = s_q.ctrl;
            OFF_SEC:  rdata_o = {s_q.halt, s_q.sec};
            OFF_MIN:  rdata_o = {1'b0, s_q.min};
            OFF_HOUR: rdata_o = {2'b00, s_q.hour};
            OFF_WDAY: rdata_o = {1'b0, s_q.cent, 3'b000, s_q.wday};
            OFF_DATE: rdata_o = {2'b00, s_q.date};
            OFF_MON:  rdata_o = {3'b000, s_q.mon};
            OFF_YEAR: rdata_o = s_q.year;
            default:  rdata_o = 8'h00;
        endcase
    end

    // R6
    sec_bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sec <= 7'h59) && (s_q.sec[3:0] <= 4'd9) && (s_q.min <= 7'h59));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.halt && !we_i) |=> ($stable(s_q.sec) && $stable(s_q.min) && $stable(s_q.date)));

    // R10
    ctrl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl[7] && s_q.ctrl[4] && !s_q.ctrl[5]);

    // R7
    hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'd3 && wdata_i[5:0] > 6'h23 && !tick_i) |=> $stable(s_q.hour));

    // R8
    date_month_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.date != 6'h00) && (s_q.date <= 6'h31) && (s_q.mon != 5'h00) && (s_q.mon <= 5'h12));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !s_q.halt && !we_i && s_q.sec == 7'h59) |=> (s_q.sec == 7'h00));

endmodule

// File: tb/sim_tod_regbank.sv
module sim_tod_regbank;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       we_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    bit [7:0] m_ctrl;
    bit       m_halt;
    bit [6:0] m_sec, m_min;
    bit [5:0] m_hour;
    bit       m_cent;
    bit [2:0] m_wday;
    bit [5:0] m_date;
    bit [4:0] m_mon;
    bit [7:0] m_year;

    tod_regbank u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [7:0] b_inc(input bit [7:0] v);
        int n = v[7:4] * 10 + v[3:0] + 1;
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic bit b_ok(input bit [7:0] v);
        return (v[3:0] < 10) && (v[7:4] < 10);
    endfunction

    function automatic bit [5:0] b_last(input bit [4:0] mo, input bit [7:0] yr);
        int y = 1900 + yr[7:4] * 10 + yr[3:0];
        case (mo)
            5'h02: return (y % 4 == 0) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default: return 6'h31;
        endcase
    endfunction

    function automatic bit [7:0] exp_rd(input int a);
        case (a)
            0: return m_ctrl;
            1: return {m_halt, m_sec};
            2: return {1'b0, m_min};
            3: return {2'b0, m_hour};
            4: return {1'b0, m_cent, 3'b0, m_wday};
            5: return {2'b0, m_date};
            6: return {3'b0, m_mon};
            default: return m_year;
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 8'h90; m_halt = 0; m_sec = 0; m_min = 0; m_hour = 0;
        m_cent = 0; m_wday = 1; m_date = 6'h01; m_mon = 5'h01; m_year = 0;
    endtask

    task automatic model_step(input bit we, input bit [2:0] a, input bit [7:0] d, input bit tk);
        bit [7:0] f;
        if (tk && !m_halt) begin
            if (m_sec != 7'h59) m_sec = 7'(b_inc({1'b0, m_sec}));
            else begin
                m_sec = 0;
                if (m_min != 7'h59) m_min = 7'(b_inc({1'b0, m_min}));
                else begin
                    m_min = 0;
                    if (m_hour != 6'h23) m_hour = 6'(b_inc({2'b0, m_hour}));
                    else begin
                        m_hour = 0;
                        m_wday = (m_wday == 7) ? 3'd1 : m_wday + 3'd1;
                        if (m_date < b_last(m_mon, m_year)) m_date = 6'(b_inc({2'b0, m_date}));
                        else begin
                            m_date = 6'h01;
                            if (m_mon != 5'h12) m_mon = 5'(b_inc({3'b0, m_mon}));
                            else begin
                                m_mon = 5'h01;
                                m_year = (m_year == 8'h99) ? 8'h00 : b_inc(m_year);
                            end
                        end
                    end
                end
            end
        end
        if (we) begin
            case (a)
                0: m_ctrl = (d & 8'h5F) | 8'h90;
                1: begin
                    m_halt = d[7];
                    f = {1'b0, d[6:0]};
                    if (b_ok(f) && f <= 8'h59) m_sec = f[6:0];
                end
                2: begin f = {1'b0, d[6:0]}; if (b_ok(f) && f <= 8'h59) m_min = f[6:0]; end
                3: begin f = {2'b0, d[5:0]}; if (b_ok(f) && f <= 8'h23) m_hour = f[5:0]; end
                4: begin m_cent = d[6]; m_wday = d[2:0]; end
                5: begin f = {2'b0, d[5:0]}; if (b_ok(f) && f != 0 && f <= 8'h31) m_date = f[5:0]; end
                6: begin f = {3'b0, d[4:0]}; if (b_ok(f) && f != 0 && f <= 8'h12) m_mon = f[4:0]; end
                default: if (b_ok(d)) m_year = d;
            endcase
        end
    endtask

    task automatic step(input bit we, input bit [2:0] a, input bit [7:0] d, input bit tk);
        @(negedge clk);
        we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
        @(posedge clk);
        #1;
        model_step(we, a, d, tk);
        we_i = 0; tick_i = 0;
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        step(1, a, d, 0);
    endtask

    task automatic tk();
        step(0, 3'd0, 8'h00, 1);
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            addr_i = 3'(a);
            #1;
            n_checks++;
            if (rdata_o !== exp_rd(a)) begin
                n_err++;
                $display("FAIL %s offset %0d: actual %h expected %h", req, a, rdata_o, exp_rd(a));
            end
        end
    endtask

    task automatic set_time(input bit [7:0] yr, input bit [7:0] mo, input bit [7:0] dt,
                            input bit [7:0] hr, input bit [7:0] mi, input bit [7:0] se);
        wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd3, hr); wr(3'd2, mi); wr(3'd1, se);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_all("R1");

        // R2 carries up to the day
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
        tk(); check_all("R2");
        tk(); check_all("R3 leap February");
        // R3 non-leap year
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tk(); check_all("R3 non-leap February");
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        tk(); check_all("R3 thirty-day month");
        wr(3'd4, 8'h07);
        set_time(8'h23, 8'h05, 8'h10, 8'h23, 8'h59, 8'h59);
        tk(); check_all("R3 weekday wrap");
        // R4 year wrap
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        tk(); check_all("R4");

        // R5 halt
        wr(3'd1, 8'h90);
        tk(); tk(); tk(); check_all("R5 halted");
        wr(3'd1, 8'hEA); check_all("R5 halt loaded on rejected seconds");
        wr(3'd1, 8'h10); tk(); check_all("R5 resumed");

        // R6..R9 rejected values
        wr(3'd1, 8'h60); check_all("R6 seconds 60");
        wr(3'd2, 8'h1A); check_all("R6 minutes bad digit");
        wr(3'd3, 8'h24); check_all("R7 hours 24");
        wr(3'd3, 8'hD5); check_all("R7 hours masked");
        wr(3'd5, 8'h00); check_all("R8 date zero");
        wr(3'd5, 8'h32); check_all("R8 date 32");
        wr(3'd6, 8'h13); check_all("R8 month 13");
        wr(3'd6, 8'h00); check_all("R8 month zero");
        wr(3'd7, 8'hA0); check_all("R9 year bad digit");
        wr(3'd7, 8'h68); check_all("R9 year accepted");

        // R10 control
        wr(3'd0, 8'hFF); check_all("R10 all ones");
        wr(3'd0, 8'h00); check_all("R10 zero");
        // R11 weekday/century
        wr(3'd4, 8'hFF); check_all("R11");
        wr(3'd4, 8'h03); check_all("R11 century clear");

        // R12 write and tick together
        wr(3'd1, 8'h59);
        step(1, 3'd2, 8'h30, 1); check_all("R12");

        // random mix
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] d;
            d = ($urandom % 2) ? 8'($urandom) : {4'($urandom % 6), 4'($urandom % 10)};
            if ($urandom % 3 == 0) step(1, 3'($urandom), d, 1'($urandom));
            else step(0, 3'd0, 8'h00, 1);
            if (i % 25 == 0) check_all("R6 R7 R8 R9 R11 R12 random");
        end
        check_all("R2 R3 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule